// File: doc/BRIEF.md
# Byte-Wise Coherent Sample Register

This block keeps one 24-bit result from a converter or filter and lets an 8-bit bus fetch it as separate byte reads. A multi-byte fetch must not mix bytes from two samples. The first byte read locks the register, and the producer can no longer replace it. The lock is released when the bus reads one selected lane, the key lane, which the bus side picks with a 2-bit input. Software therefore sets the key to the last lane its field needs, and fields of 8, 16 or 24 bits all transfer coherently.

Samples that arrive while the register is locked are not discarded at once. They wait in a one-deep shadow register and are copied in on the cycle the lock releases. When a pending sample is replaced before it is copied in, a sticky overrun status bit is set. A write-one strobe clears that bit.

Top module: `coh_result_reg`

## Requirements
- R1: After reset the result holds 0, the register is unlocked, and `overrun` is 0. With `keySel` at 0 (lane 0 as key), a read of lane 0 returns 0x00.
- R2: While unlocked, a `sampleValid` pulse loads `sampleIn`. The following reads return its bytes: `rdAddr` 0 gives bits 7:0, 1 gives bits 15:8, and 2 gives bits 23:16. Read data is valid in the same cycle as `rdStrobe`.
- R3: While unlocked, reading a lane other than the key lane locks the register. While locked, producer samples do not change any byte the bus reads.
- R4: While locked, reading the lane captured as key releases the lock. Reading any other lane leaves it locked.
- R5: `keySel` codes are 00 for lane 0, 01 for lane 1 and 10 for lane 2. Code 11 acts exactly like 10.
- R6: While unlocked, a read of the key lane does not lock. It is a complete single-byte access, and a later sample still loads.
- R7: A sample that arrives while locked is held in a shadow and becomes readable right after the releasing read. A newer arrival replaces an older pending one. A sample that arrives in the releasing cycle wins over the pending one.
- R8: When a pending shadow sample is dropped before it is copied in, `overrun` goes to 1 and stays there. A `overrunClr` pulse clears it. A new drop in the same cycle as a clear leaves it at 1.
- R9: A change of `keySel` while locked has no effect until the current lock releases. The key lane captured at lock time still governs the release.
- R10: `rdAddr` 3 returns 0x00. It neither locks nor releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 24 | Sample from the producer |
| sampleValid | input | 1 | One-cycle strobe qualifying `sampleIn` |
| rdAddr | input | 2 | Lane number of the byte read |
| rdStrobe | input | 1 | Byte read this cycle |
| rdData | output | 8 | Byte selected by `rdAddr` |
| keySel | input | 2 | Key lane code |
| overrunClr | input | 1 | Write-one clear of `overrun` |
| overrun | output | 1 | Sticky flag: a pending sample was dropped |

## Verification
The bench reads three kinds of field through the lock: a full 24-bit field with the key on the low lane, and 16-bit upper fields with key codes 10 and 11. The 16-bit fields show whether release follows the key rather than a fixed lane. Producer pulses are placed before the lock, during it, twice during it, and in the releasing cycle itself. These placements separate a plain update, a shadow copy, a replacement with overrun, and the case where the newest sample wins. Key changes during a lock, together with reads of lane 3, show that the captured key governs the release and that the empty address has no side effect.

// File: rtl/cohres_pkg.sv
package cohres_pkg;

  // Update strobes sent from the control to the datapath.
  typedef struct packed {
    logic loadNew;        // copy sampleIn into the result
    logic loadShadow;     // copy the shadow into the result
    logic captureShadow;  // park sampleIn in the shadow
  } dpStrobe_t;

endpackage

// File: rtl/cohres_ctrl.sv
module cohres_ctrl
  import cohres_pkg::*;
#(
  parameter int LANE_CNT = 3,
  localparam int ADDR_W = $clog2(LANE_CNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] keySel,
  input  logic              overrunClr,
  output dpStrobe_t         strobe,
  output logic              lockedQ,
  output logic [ADDR_W-1:0] lockKeyQ,
  output logic              pendQ,
  output logic              overrunQ
);

  localparam logic [ADDR_W-1:0] TOP_LANE = ADDR_W'(LANE_CNT - 1);

  logic [ADDR_W-1:0] liveKey;
  logic laneHit, lockNow, releaseNow, holdOff, dropPend;

  // Codes above the top lane select the top lane.
  assign liveKey    = (keySel > TOP_LANE) ? TOP_LANE : keySel;
  assign laneHit    = rdStrobe && (rdAddr <= TOP_LANE);
  assign lockNow    = !lockedQ && laneHit && (rdAddr != liveKey);
  assign releaseNow = lockedQ && laneHit && (rdAddr == lockKeyQ);
  assign holdOff    = (lockedQ && !releaseNow) || lockNow;

  always_comb begin
    strobe.loadNew       = sampleValid && !holdOff;
    strobe.loadShadow    = releaseNow && pendQ && !sampleValid;
    strobe.captureShadow = sampleValid && holdOff;
  end

  assign dropPend = pendQ && sampleValid && (holdOff || releaseNow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ  <= 1'b0;
      lockKeyQ <= '0;
      pendQ    <= 1'b0;
      overrunQ <= 1'b0;
    end else begin
      if (lockNow) begin
        lockedQ  <= 1'b1;
        lockKeyQ <= liveKey;
      end else if (releaseNow) begin
        lockedQ <= 1'b0;
      end

      if (strobe.captureShadow)  pendQ <= 1'b1;
      else if (releaseNow)       pendQ <= 1'b0;

      if (dropPend)              overrunQ <= 1'b1;
      else if (overrunClr)       overrunQ <= 1'b0;
    end
  end

endmodule

// File: rtl/cohres_datapath.sv
module cohres_datapath
  import cohres_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int LANE_CNT = 3,
  localparam int DATA_W = LANE_W * LANE_CNT,
  localparam int ADDR_W = $clog2(LANE_CNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [LANE_W-1:0] rdData,
  output logic [DATA_W-1:0] resultQ,
  output logic [DATA_W-1:0] shadowQ
);

  localparam logic [ADDR_W-1:0] TOP_LANE = ADDR_W'(LANE_CNT - 1);

  logic [LANE_W-1:0] lanes [LANE_CNT];

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    assign lanes[g] = resultQ[g*LANE_W +: LANE_W];
  end

  assign rdData = (rdAddr <= TOP_LANE) ? lanes[rdAddr] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      shadowQ <= '0;
    end else begin
      if (strobe.loadNew)         resultQ <= sampleIn;
      else if (strobe.loadShadow) resultQ <= shadowQ;
      if (strobe.captureShadow)   shadowQ <= sampleIn;
    end
  end

endmodule

// File: rtl/coh_result_reg.sv
module coh_result_reg
  import cohres_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int LANE_CNT = 3,
  localparam int DATA_W = LANE_W * LANE_CNT,
  localparam int ADDR_W = $clog2(LANE_CNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobe,
  output logic [LANE_W-1:0] rdData,
  input  logic [ADDR_W-1:0] keySel,
  input  logic              overrunClr,
  output logic              overrun
);

  dpStrobe_t         strobe;
  logic              lockedQ;
  logic [ADDR_W-1:0] lockKeyQ;
  logic              pendQ;
  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] shadowQ;

  cohres_ctrl #(.LANE_CNT(LANE_CNT)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .rdStrobe   (rdStrobe),
    .rdAddr     (rdAddr),
    .keySel     (keySel),
    .overrunClr (overrunClr),
    .strobe     (strobe),
    .lockedQ    (lockedQ),
    .lockKeyQ   (lockKeyQ),
    .pendQ      (pendQ),
    .overrunQ   (overrun)
  );

  cohres_datapath #(.LANE_W(LANE_W), .LANE_CNT(LANE_CNT)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sampleIn(sampleIn),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .resultQ (resultQ),
    .shadowQ (shadowQ)
  );

endmodule

// File: rtl/coh_result_reg_chk.sv
module coh_result_reg_chk #(
  parameter int LANE_W   = 8,
  parameter int LANE_CNT = 3,
  localparam int DATA_W = LANE_W * LANE_CNT,
  localparam int ADDR_W = $clog2(LANE_CNT + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] sampleIn,
  input logic              sampleValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdStrobe,
  input logic [LANE_W-1:0] rdData,
  input logic [ADDR_W-1:0] keySel,
  input logic              overrun,
  input logic              lockedQ,
  input logic [ADDR_W-1:0] lockKeyQ,
  input logic              pendQ,
  input logic [DATA_W-1:0] resultQ,
  input logic [DATA_W-1:0] shadowQ
);

  localparam logic [ADDR_W-1:0] TOP_LANE = ADDR_W'(LANE_CNT - 1);

  logic relHit;
  logic [ADDR_W-1:0] keyLane;
  assign relHit  = lockedQ && rdStrobe && (rdAddr == lockKeyQ);
  assign keyLane = (keySel > TOP_LANE) ? TOP_LANE : keySel;

  p_hold_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ && !relHit |=> $stable(resultQ));

  p_release_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    relHit |=> !lockedQ);

  p_key_read_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    !lockedQ && rdStrobe && (rdAddr == keyLane) |=> !lockedQ);

  p_shadow_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    relHit && pendQ && !sampleValid |=> resultQ == $past(shadowQ));

  p_newest_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    relHit && sampleValid |=> resultQ == $past(sampleIn));

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ && !relHit && sampleValid && pendQ |=> overrun);

  p_key_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ && !relHit |=> lockKeyQ == $past(lockKeyQ));

  p_empty_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && (rdAddr > TOP_LANE) |-> rdData == '0);

endmodule

bind coh_result_reg coh_result_reg_chk #(.LANE_W(LANE_W), .LANE_CNT(LANE_CNT)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sampleIn   (sampleIn),
  .sampleValid(sampleValid),
  .rdAddr     (rdAddr),
  .rdStrobe   (rdStrobe),
  .rdData     (rdData),
  .keySel     (keySel),
  .overrun    (overrun),
  .lockedQ    (lockedQ),
  .lockKeyQ   (lockKeyQ),
  .pendQ      (pendQ),
  .resultQ    (resultQ),
  .shadowQ    (shadowQ)
);

// File: tb/coh_result_reg_tb_top.sv
`timescale 1ns/1ps
module coh_result_reg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic        rdStrobe = 1'b0;
  logic [7:0]  rdData;
  logic [1:0]  keySel = 2'd0;
  logic        overrunClr = 1'b0;
  logic        overrun;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2 clk = ~clk;

  coh_result_reg dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .rdAddr(rdAddr), .rdStrobe(rdStrobe), .rdData(rdData),
    .keySel(keySel), .overrunClr(overrunClr), .overrun(overrun)
  );

  // Monitor: pops the expected byte for every read strobe.
  always @(negedge clk) begin
    if (rstN && rdStrobe) begin
      logic [7:0] e;
      string t;
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read, actual %h expected none", "scoreboard", rdData);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL %s: rdData actual %h expected %h", t, rdData, e);
        end
      end
    end
  end

  // Driver: one bus/producer cycle; pushes expected read byte.
  task automatic step(input bit doS, input logic [23:0] sv, input bit doR,
                      input logic [1:0] a, input logic [7:0] e, input string tag,
                      input bit doC = 1'b0);
    @(posedge clk); #1;
    sampleValid = doS; sampleIn = sv;
    rdStrobe = doR; rdAddr = a; overrunClr = doC;
    if (doR) begin expQ.push_back(e); tagQ.push_back(tag); end
    @(posedge clk); #1;
    sampleValid = 1'b0; rdStrobe = 1'b0; overrunClr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    step(1'b0, 24'h0, 1'b1, a, e, tag);
  endtask

  task automatic smp(input logic [23:0] v);
    step(1'b1, v, 1'b0, 2'd0, 8'h0, "");
  endtask

  task automatic clr();
    step(1'b0, 24'h0, 1'b0, 2'd0, 8'h0, "", 1'b1);
  endtask

  task automatic checkOvr(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (overrun !== e) begin
      fails++;
      $display("FAIL %s: overrun actual %b expected %b", tag, overrun, e);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkOvr(1'b0, "R1");
    rd(2'd0, 8'h00, "R1");

    // R2 plain load, R6 key read does not lock
    smp(24'h123456);
    rd(2'd0, 8'h56, "R6");
    smp(24'hABCDEF);
    rd(2'd2, 8'hAB, "R2");            // locks (key lane 0)
    smp(24'h111111);                   // shadowed
    rd(2'd1, 8'hCD, "R3");
    rd(2'd0, 8'hEF, "R4");            // release, shadow copied
    rd(2'd0, 8'h11, "R7");

    // R8 overrun
    rd(2'd1, 8'h11, "R3");
    smp(24'h222222);
    smp(24'h333333);
    checkOvr(1'b1, "R8");
    rd(2'd2, 8'h11, "R3");
    rd(2'd0, 8'h11, "R4");
    rd(2'd2, 8'h33, "R7");            // newer pending replaced older
    rd(2'd0, 8'h33, "R4");
    clr();
    checkOvr(1'b0, "R8");
    rd(2'd1, 8'h33, "R3");
    smp(24'h444444);
    step(1'b1, 24'h555555, 1'b0, 2'd0, 8'h0, "", 1'b1); // drop and clear together
    checkOvr(1'b1, "R8");
    rd(2'd0, 8'h33, "R4");
    clr();
    checkOvr(1'b0, "R8");
    rd(2'd0, 8'h55, "R7");

    // R5 key code 10: 16-bit upper field
    keySel = 2'd2;
    smp(24'h0A0B0C);
    rd(2'd1, 8'h0B, "R5");
    smp(24'h1A1B1C);
    rd(2'd2, 8'h0A, "R5");
    rd(2'd2, 8'h1A, "R5");
    // key code 11 acts as high lane
    keySel = 2'd3;
    smp(24'h2A2B2C);
    rd(2'd1, 8'h2B, "R5");
    smp(24'h3A3B3C);
    rd(2'd0, 8'h2C, "R5");            // not the key: still locked
    rd(2'd2, 8'h2A, "R5");
    rd(2'd2, 8'h3A, "R5");

    // R9 key change during a lock
    keySel = 2'd0;
    smp(24'h445566);
    rd(2'd1, 8'h55, "R9");            // locks with key lane 0
    keySel = 2'd1;
    rd(2'd1, 8'h55, "R9");            // new key not yet active
    smp(24'h778899);
    rd(2'd2, 8'h44, "R9");
    rd(2'd0, 8'h66, "R9");            // old key releases
    rd(2'd1, 8'h88, "R9");            // new key: no lock
    smp(24'hAABBCC);
    rd(2'd1, 8'hBB, "R9");

    // R10 empty address
    rd(2'd3, 8'h00, "R10");
    smp(24'h010203);
    rd(2'd1, 8'h02, "R10");           // addr 3 did not lock
    rd(2'd0, 8'h03, "R3");            // locks
    rd(2'd3, 8'h00, "R10");
    smp(24'h0F0F0F);
    rd(2'd2, 8'h01, "R10");           // addr 3 did not release
    rd(2'd1, 8'h02, "R4");
    rd(2'd1, 8'h0F, "R7");

    // R7 newest wins in the releasing cycle
    rd(2'd0, 8'h0F, "R7");
    smp(24'h121212);
    step(1'b1, 24'h343434, 1'b1, 2'd1, 8'h0F, "R7");
    rd(2'd1, 8'h34, "R7");
    checkOvr(1'b1, "R8");
    clr();
    checkOvr(1'b0, "R8");

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule